// File: doc/BRIEF.md
# Delay-Slot Load Hazard Classifier

This unit looks at a load that was issued in the delay slot of a taken branch and at the instruction word fetched from the branch target. It reports how that target instruction uses the register the load is about to fill. An interpreter or a pipeline control block can use the answer to choose how to sequence the two instructions. If the target only reads the register, it must see the old value. If it only writes the register, its own result must win. If it does both, the load's write is dropped. The unit also reports whether the delay-slot instruction belongs to a class that carries a delayed result.

The result is a two-bit class. The unit decodes the major opcode, the function field of register-format instructions, the branch sub-code of the register-immediate group, and the move sub-op of coprocessor 0 and coprocessor 2. A parameter selects a registered output, which is the default, or a purely combinational one.

Top module: `hz_delay_classifier`

## Requirements
- R1: `hz_class` encodes 0 = no interaction, 1 = target reads and writes the register, 2 = target reads it only, 3 = target writes it only. Any instruction outside the decoded set yields 0. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R2: A target word of all zeros yields class 0.
- R3: A register number of 0 always yields class 0.
- R4: For op 0, decode by funct. Funct 0x00/0x02/0x03 read rt and write rd. Funct 0x04/0x06/0x07 and 0x20–0x27/0x2A/0x2B read rs and rt and write rd. Funct 0x08 reads rs. Funct 0x09 reads rs and writes rd. Funct 0x10/0x12 write rd. Funct 0x11/0x13 read rs. Funct 0x18–0x1B read rs and rt.
- R5: Op 0x04/0x05 read rs and rt. Op 0x06/0x07 read rs. Op 0x01 with rt equal to 0x00, 0x02, 0x10 or 0x12 reads rs. Op 0x03 writes register 31. Op 0x02 has no interaction.
- R6: Op 0x08–0x0E and loads 0x20/0x21/0x23/0x24/0x25 read rs and write rt. Op 0x0F writes rt only.
- R7: For op 0x22 and 0x26, an rt match gives 3 even when rs also matches. Otherwise an rs match gives 2.
- R8: Stores 0x28/0x29/0x2A/0x2B/0x2E read rs and rt. Op 0x32/0x3A read rs only.
- R9: For op 0x10, and for op 0x12 when funct is 0, the rs sub-op decides. Sub-op 0x00/0x02 writes rt. Sub-op 0x04/0x06 reads rt.
- R10: `slot_is_load` is 1 when the slot word has op 0x20–0x26 or 0x32. It is also 1 for op 0x10 with rs 0x00/0x02, and for op 0x12 with funct 0 and rs 0x00/0x02. It is 0 otherwise.
- R11: With the registered output, `hz_class` and `slot_is_load` take the result one clock after `in_valid`, and `out_valid` is `in_valid` delayed by one clock. Without a strobe the results hold.
- R12: During and straight after reset, `out_valid`, `hz_class` and `slot_is_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that qualifies the inputs |
| dst_reg | input | 5 | Register filled by the delay-slot load |
| slot_insn | input | 32 | Instruction word in the delay slot |
| tgt_insn | input | 32 | Instruction word at the branch target |
| out_valid | output | 1 | Result qualifier |
| hz_class | output | 2 | Interaction class |
| slot_is_load | output | 1 | Delay-slot instruction carries a delayed result |

## Verification
The hardest cases to reach are the ones where a single register number hits two fields of the target word at once. Examples are a register ALU op with rd, rs and rt all equal, and a partial-word load where rs and rt are both equal. These settle the priority between the read-write, read and write codes. Random words almost never produce them. The stimulus therefore builds each target from a chosen opcode, and for each field flips a coin to either copy the register number into it or fill it at random. This makes double and triple matches common across every decoded opcode. Directed words pin down the partial-load ordering and the coprocessor sub-ops.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int INSN_W  = 32;
    localparam int REG_W   = 5;
    localparam int OP_W    = 6;
    localparam int OP_LSB  = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    typedef enum logic [1:0] {
        HZ_NONE = 2'd0,
        HZ_RW   = 2'd1,
        HZ_RD   = 2'd2,
        HZ_WR   = 2'd3
    } hz_class_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
        logic [OP_W-1:0]  fn;
    } insn_fields_t;

    typedef struct packed {
        logic rd_rs;
        logic rd_rt;
        logic wr_rd;
        logic wr_rt;
        logic wr_link;
        logic wr_first;
    } reg_use_t;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'h01;
    localparam logic [OP_W-1:0] OP_JAL     = 6'h03;
    localparam logic [OP_W-1:0] OP_COP0    = 6'h10;
    localparam logic [OP_W-1:0] OP_COP2    = 6'h12;
    localparam logic [OP_W-1:0] OP_LUI     = 6'h0F;
    localparam logic [OP_W-1:0] OP_LWC2    = 6'h32;
    localparam logic [OP_W-1:0] OP_SWC2    = 6'h3A;

    function automatic insn_fields_t split_insn(input logic [INSN_W-1:0] w);
        insn_fields_t f;
        f.op = w[OP_LSB +: OP_W];
        f.rs = w[RS_LSB +: REG_W];
        f.rt = w[RT_LSB +: REG_W];
        f.rd = w[RD_LSB +: REG_W];
        f.fn = w[OP_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/hz_use_decode.sv
module hz_use_decode
    import hz_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output reg_use_t          use_o
);
    insn_fields_t f;
    assign f = split_insn(insn);

    always_comb begin
        use_o = '0;
        case (f.op)
            OP_SPECIAL: begin
                case (f.fn)
                    6'h00, 6'h02, 6'h03: begin
                        use_o.rd_rt = 1'b1;
                        use_o.wr_rd = 1'b1;
                    end
                    6'h04, 6'h06, 6'h07,
                    6'h20, 6'h21, 6'h22, 6'h23,
                    6'h24, 6'h25, 6'h26, 6'h27,
                    6'h2A, 6'h2B: begin
                        use_o.rd_rs = 1'b1;
                        use_o.rd_rt = 1'b1;
                        use_o.wr_rd = 1'b1;
                    end
                    6'h08: use_o.rd_rs = 1'b1;
                    6'h09: begin
                        use_o.rd_rs = 1'b1;
                        use_o.wr_rd = 1'b1;
                    end
                    6'h10, 6'h12: use_o.wr_rd = 1'b1;
                    6'h11, 6'h13: use_o.rd_rs = 1'b1;
                    6'h18, 6'h19, 6'h1A, 6'h1B: begin
                        use_o.rd_rs = 1'b1;
                        use_o.rd_rt = 1'b1;
                    end
                    default: use_o = '0;
                endcase
            end
            OP_REGIMM: begin
                case (f.rt)
                    5'h00, 5'h02, 5'h10, 5'h12: use_o.rd_rs = 1'b1;
                    default: use_o = '0;
                endcase
            end
            OP_JAL: use_o.wr_link = 1'b1;
            6'h04, 6'h05: begin
                use_o.rd_rs = 1'b1;
                use_o.rd_rt = 1'b1;
            end
            6'h06, 6'h07: use_o.rd_rs = 1'b1;
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                use_o.rd_rs = 1'b1;
                use_o.wr_rt = 1'b1;
            end
            OP_LUI: use_o.wr_rt = 1'b1;
            6'h22, 6'h26: begin
                use_o.rd_rs    = 1'b1;
                use_o.wr_rt    = 1'b1;
                use_o.wr_first = 1'b1;
            end
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E: begin
                use_o.rd_rs = 1'b1;
                use_o.rd_rt = 1'b1;
            end
            OP_LWC2, OP_SWC2: use_o.rd_rs = 1'b1;
            OP_COP0, OP_COP2: begin
                if (f.op == OP_COP0 || f.fn == 6'h00) begin
                    case (f.rs)
                        5'h00, 5'h02: use_o.wr_rt = 1'b1;
                        5'h04, 5'h06: use_o.rd_rt = 1'b1;
                        default: use_o = '0;
                    endcase
                end
            end
            default: use_o = '0;
        endcase
    end
endmodule

// File: rtl/hz_class_resolve.sv
module hz_class_resolve
    import hz_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [REG_W-1:0]  reg_no,
    input  reg_use_t          use_i,
    output hz_class_e         cls
);
    localparam logic [REG_W-1:0] LINK = REG_W'(LINK_REG);

    insn_fields_t f;
    logic         read_hit;
    logic         write_hit;
    logic         blank;

    assign f = split_insn(insn);

    always_comb begin
        read_hit  = (use_i.rd_rs && f.rs == reg_no) ||
                    (use_i.rd_rt && f.rt == reg_no);
        write_hit = (use_i.wr_rd && f.rd == reg_no) ||
                    (use_i.wr_rt && f.rt == reg_no) ||
                    (use_i.wr_link && reg_no == LINK);
        blank     = (insn == '0) || (reg_no == '0);

        if (blank) begin
            cls = HZ_NONE;
        end else if (use_i.wr_first) begin
            if (write_hit)     cls = HZ_WR;
            else if (read_hit) cls = HZ_RD;
            else               cls = HZ_NONE;
        end else begin
            case ({read_hit, write_hit})
                2'b11:   cls = HZ_RW;
                2'b10:   cls = HZ_RD;
                2'b01:   cls = HZ_WR;
                default: cls = HZ_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hz_load_detect.sv
module hz_load_detect
    import hz_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic              is_load
);
    insn_fields_t f;
    logic         mv_from;

    assign f       = split_insn(insn);
    assign mv_from = (f.rs == 5'h00) || (f.rs == 5'h02);

    always_comb begin
        case (f.op)
            6'h20, 6'h21, 6'h22, 6'h23,
            6'h24, 6'h25, 6'h26: is_load = 1'b1;
            OP_LWC2:             is_load = 1'b1;
            OP_COP0:             is_load = mv_from;
            OP_COP2:             is_load = mv_from && (f.fn == 6'h00);
            default:             is_load = 1'b0;
        endcase
    end
endmodule

// File: rtl/hz_delay_classifier.sv
module hz_delay_classifier
    import hz_pkg::*;
#(
    parameter bit REG_OUT  = 1'b1,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [INSN_W-1:0] slot_insn,
    input  logic [INSN_W-1:0] tgt_insn,
    output logic              out_valid,
    output logic [1:0]        hz_class,
    output logic              slot_is_load
);
    typedef struct packed {
        logic      vld;
        hz_class_e cls;
        logic      trig;
    } res_t;

    reg_use_t  tgt_use;
    hz_class_e cls_now;
    logic      trig_now;
    res_t      res_d;
    res_t      res_q;

    hz_use_decode u_use (
        .insn  (tgt_insn),
        .use_o (tgt_use)
    );

    hz_class_resolve #(.LINK_REG(LINK_REG)) u_resolve (
        .insn   (tgt_insn),
        .reg_no (dst_reg),
        .use_i  (tgt_use),
        .cls    (cls_now)
    );

    hz_load_detect u_trig (
        .insn    (slot_insn),
        .is_load (trig_now)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.cls  = cls_now;
            res_d.trig = trig_now;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '{vld: 1'b0, cls: HZ_NONE, trig: 1'b0};
                else        res_q <= res_d;
            end
            assign out_valid    = res_q.vld;
            assign hz_class     = res_q.cls;
            assign slot_is_load = res_q.trig;
        end else begin : g_comb
            assign res_q        = '{vld: 1'b0, cls: HZ_NONE, trig: 1'b0};
            assign out_valid    = in_valid;
            assign hz_class     = cls_now;
            assign slot_is_load = trig_now;
        end
    endgenerate
endmodule

// File: rtl/hz_delay_classifier_chk.sv
module hz_delay_classifier_chk
    import hz_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [REG_W-1:0]  dst_reg,
    input logic [INSN_W-1:0] slot_insn,
    input logic [INSN_W-1:0] tgt_insn,
    input logic              out_valid,
    input logic [1:0]        hz_class,
    input logic              slot_is_load
);
    generate
        if (REG_OUT) begin : g_props
            assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_valid_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(hz_class) && $stable(slot_is_load)));
            assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && dst_reg == '0) |=> hz_class == 2'd0);
            assert_blank_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && tgt_insn == '0) |=> hz_class == 2'd0);
            assert_link_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && tgt_insn[31:26] == 6'h03 && dst_reg == 5'd31) |=> hz_class == 2'd3);
            assert_load_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && slot_insn[31:26] >= 6'h20 && slot_insn[31:26] <= 6'h26) |=> slot_is_load);
        end
    endgenerate
endmodule

bind hz_delay_classifier hz_delay_classifier_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_hz_delay_classifier.sv
`timescale 1ns/1ps
module tb_hz_delay_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  dst_reg = '0;
    logic [31:0] slot_insn = '0;
    logic [31:0] tgt_insn = '0;
    logic        out_valid;
    logic [1:0]  hz_class;
    logic        slot_is_load;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int    exp_cls  = 0;
    int    exp_trig = 0;
    int    exp_vld  = 0;
    string exp_tag  = "R12";

    always #2.5 clk = ~clk;

    hz_delay_classifier dut (.*);

    function automatic int ref_class(int r, logic [31:0] w);
        int op = int'(w[31:26]);
        int rs = int'(w[25:21]);
        int rt = int'(w[20:16]);
        int rd = int'(w[15:11]);
        int fn = int'(w[5:0]);
        bit rdh = 0;
        bit wrh = 0;
        if (w == 0 || r == 0) return 0;
        case (op) inside
            0: case (fn) inside
                   0, 2, 3:                 begin rdh = (rt == r); wrh = (rd == r); end
                   4, 6, 7, [32:39], 42, 43: begin rdh = (rs == r || rt == r); wrh = (rd == r); end
                   8:                        rdh = (rs == r);
                   9:                        begin rdh = (rs == r); wrh = (rd == r); end
                   16, 18:                   wrh = (rd == r);
                   17, 19:                   rdh = (rs == r);
                   [24:27]:                  rdh = (rs == r || rt == r);
                   default: ;
               endcase
            1: if (rt == 0 || rt == 2 || rt == 16 || rt == 18) rdh = (rs == r);
            3: wrh = (r == 31);
            4, 5: rdh = (rs == r || rt == r);
            6, 7: rdh = (rs == r);
            [8:14], 32, 33, 35, 36, 37: begin rdh = (rs == r); wrh = (rt == r); end
            15: wrh = (rt == r);
            34, 38: return (rt == r) ? 3 : ((rs == r) ? 2 : 0);
            40, 41, 42, 43, 46: rdh = (rs == r || rt == r);
            50, 58: rdh = (rs == r);
            16, 18: if (op == 16 || fn == 0) begin
                if (rs == 0 || rs == 2) wrh = (rt == r);
                if (rs == 4 || rs == 6) rdh = (rt == r);
            end
            default: ;
        endcase
        if (rdh && wrh) return 1;
        if (rdh) return 2;
        if (wrh) return 3;
        return 0;
    endfunction

    function automatic int ref_trig(logic [31:0] w);
        int op = int'(w[31:26]);
        int rs = int'(w[25:21]);
        if (op >= 32 && op <= 38) return 1;
        if (op == 50) return 1;
        if (op == 16 && (rs == 0 || rs == 2)) return 1;
        if (op == 18 && w[5:0] == 0 && (rs == 0 || rs == 2)) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] mk(int op, int rs, int rt, int rd, int fn);
        return {op[5:0], rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    task automatic check_now();
        checks++;
        if (int'(out_valid) != exp_vld) begin
            fails++;
            $display("FAIL %s out_valid actual %0d expected %0d", exp_tag, out_valid, exp_vld);
        end
        checks++;
        if (int'(hz_class) != exp_cls) begin
            fails++;
            $display("FAIL %s hz_class actual %0d expected %0d", exp_tag, hz_class, exp_cls);
        end
        checks++;
        if (int'(slot_is_load) != exp_trig) begin
            fails++;
            $display("FAIL %s slot_is_load actual %0d expected %0d", exp_tag, slot_is_load, exp_trig);
        end
    endtask

    task automatic step(bit v, int r, logic [31:0] slot, logic [31:0] tgt, string tag);
        @(negedge clk);
        check_now();
        in_valid  = v;
        dst_reg   = r[4:0];
        slot_insn = slot;
        tgt_insn  = tgt;
        exp_vld   = v;
        exp_tag   = tag;
        if (v) begin
            exp_cls  = ref_class(r, tgt);
            exp_trig = ref_trig(slot);
        end
    endtask

    localparam logic [31:0] LW_SLOT = 32'h8C05_0000;

    initial begin
        repeat (3) @(negedge clk);
        check_now();                        // R12 during reset
        rst_n = 1'b1;
        step(0, 0, '0, '0, "R12");          // R12 right after reset
        step(1, 5, LW_SLOT, 32'h0, "R2");
        step(1, 0, LW_SLOT, mk(0, 0, 0, 0, 32), "R3");
        step(1, 5, LW_SLOT, mk(0, 5, 5, 5, 33), "R1");
        step(1, 5, LW_SLOT, mk(0, 0, 5, 9, 0), "R4");
        step(1, 5, LW_SLOT, mk(0, 0, 0, 5, 16), "R4");
        step(1, 5, LW_SLOT, mk(0, 5, 1, 5, 9), "R4");
        step(1, 5, LW_SLOT, mk(0, 5, 6, 0, 26), "R4");
        step(1, 5, LW_SLOT, mk(0, 5, 5, 5, 5), "R1");
        step(1, 31, LW_SLOT, mk(3, 0, 0, 0, 0), "R5");
        step(1, 31, LW_SLOT, mk(2, 31, 31, 31, 0), "R5");
        step(1, 5, LW_SLOT, mk(1, 5, 16, 0, 0), "R5");
        step(1, 5, LW_SLOT, mk(1, 5, 3, 0, 0), "R5");
        step(1, 5, LW_SLOT, mk(4, 1, 5, 0, 0), "R5");
        step(1, 5, LW_SLOT, mk(8, 5, 5, 0, 0), "R6");
        step(1, 5, LW_SLOT, mk(15, 5, 5, 0, 0), "R6");
        step(1, 5, LW_SLOT, mk(35, 1, 5, 0, 0), "R6");
        step(1, 5, LW_SLOT, mk(34, 5, 5, 0, 0), "R7");
        step(1, 5, LW_SLOT, mk(38, 5, 2, 0, 0), "R7");
        step(1, 5, LW_SLOT, mk(43, 2, 5, 0, 0), "R8");
        step(1, 5, LW_SLOT, mk(58, 1, 5, 0, 0), "R8");
        step(1, 5, LW_SLOT, mk(50, 5, 1, 0, 0), "R8");
        step(1, 5, LW_SLOT, mk(16, 2, 5, 0, 0), "R9");
        step(1, 5, LW_SLOT, mk(16, 6, 5, 0, 0), "R9");
        step(1, 5, LW_SLOT, mk(18, 0, 5, 0, 0), "R9");
        step(1, 5, LW_SLOT, mk(18, 0, 5, 0, 1), "R9");
        step(1, 5, mk(16, 0, 5, 0, 0), mk(0, 0, 0, 0, 13), "R10");
        step(1, 5, mk(18, 2, 5, 0, 3), mk(0, 0, 0, 0, 0), "R10");
        step(1, 5, mk(18, 2, 5, 0, 0), 32'h0, "R10");
        step(1, 5, mk(43, 2, 5, 0, 0), 32'h0, "R10");
        step(1, 5, mk(50, 2, 5, 0, 0), mk(4, 5, 0, 0, 0), "R10");
        step(0, 7, mk(0, 0, 0, 0, 0), mk(0, 7, 7, 7, 32), "R11");
        step(0, 7, mk(0, 0, 0, 0, 0), mk(3, 7, 7, 7, 32), "R11");
        for (int i = 0; i < 2000; i++) begin
            int ops[26] = '{0, 0, 0, 1, 2, 3, 4, 6, 8, 13, 15, 16, 18, 18,
                            32, 34, 35, 38, 40, 43, 46, 50, 58, 20, 63, 7};
            int fns[14] = '{0, 2, 3, 4, 8, 9, 16, 17, 24, 27, 32, 39, 42, 12};
            int r  = int'($urandom_range(0, 31));
            int op = ops[$urandom_range(0, 25)];
            int rs = ($urandom_range(0, 1) == 1) ? r : int'($urandom_range(0, 31));
            int rt = ($urandom_range(0, 1) == 1) ? r : int'($urandom_range(0, 31));
            int rd = ($urandom_range(0, 1) == 1) ? r : int'($urandom_range(0, 31));
            int fn = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63)) : fns[$urandom_range(0, 13)];
            if (op == 16 || op == 18) rs = int'($urandom_range(0, 7));
            if (op == 1) rt = ($urandom_range(0, 1) == 1) ? 16 : rt;
            step(bit'($urandom_range(0, 3) != 0), r,
                 mk(ops[$urandom_range(0, 25)], int'($urandom_range(0, 7)), r, 0,
                    ($urandom_range(0, 1) == 1) ? 0 : int'($urandom_range(0, 63))),
                 mk(op, rs, rt, rd, fn), "R1 R4-R11 random");
        end
        step(0, 0, '0, '0, "R11");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule